// File: doc/BRIEF.md
# Programmable Modulus Down-Counter

This block is a 16-bit down-counter for periodic or single timeouts. It keeps a separate load register and a fixed-ratio prescaler. Software reaches it through a small register port with two word addresses. Address 0 holds the control word and address 1 holds the count. A write to the count address always sets the load register. When the counter is enabled, the same write also restarts counting from the written value.

The counter decrements once per prescaler tick. In one-shot mode it stops at zero. In periodic mode it reloads from the load register on the tick after it reaches zero. A one-cycle `zero_pulse` marks each arrival at zero. A self-clearing strobe in the control word copies the load register into the count and restarts the prescaler. The strobe acts only while the counter is enabled. Clearing the enable parks the count at 0x00FF.

The sequencing is a three-state machine:
- IDLE: the counter is disabled.
- RUN: the counter is counting.
- HOLD: a one-shot run has ended at zero.

Its transitions are:
- enable: IDLE to RUN.
- disable: RUN or HOLD to IDLE.
- expire: RUN to HOLD, when the count reaches zero in one-shot mode.
- restart: RUN or HOLD to RUN, on a force-load or a count write.
- wrap: RUN to RUN, on a periodic reload.

Top module: `moddown_timer`

## Requirements
- R1: In one-shot mode (control bit 1 = 0) the count steps down to 0x0000 once and then holds at 0x0000 (HOLD state) until a restart or a disable.
- R2: In periodic mode (control bit 1 = 1), a prescaler tick that finds the count at 0x0000 loads the count from the load register.
- R3: A read of address 1 returns the live count when control bit 2 is 0, and returns the load register when control bit 2 is 1.
- R4: Writing address 0 with bit 3 = 1 and bit 0 = 1, while already enabled, copies the load register into the count on the next edge. The next decrement then follows DIV cycles later.
- R5: A force-load write made while the counter is disabled leaves the count at 0x00FF.
- R6: Bit 3 of address 0 always reads 0. A control write with bit 3 = 0 forces nothing.
- R7: While control bit 0 (enable) is 0, the count reads 0x00FF from the first edge after reset onward.
- R8: A write to address 1 always sets the load register. While enabled, the count takes the written value on the next edge.
- R9: While running, the count decrements exactly once per DIV clock cycles.
- R10: `zero_pulse` is high for one cycle on each arrival of the count at 0x0000. A one-shot run produces exactly one pulse.
- R11: Synchronous active-high reset clears the control word, the count, the load register and `zero_pulse` to 0.
- R12: Address 0 reads the enable at bit 0, the mode at bit 1 and the read select at bit 2, with all other bits 0. These fields change only on a write to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 1 | 0 = control word, 1 = count word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed word (combinational) |
| zero_pulse | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The bench builds the counter with DIV = 3 and the default 16-bit width. The non-trivial prescaler makes the gap between the restart edge and the first decrement visible at the ports. It also separates a force-load's prescaler restart from an ordinary tick, and lets a periodic wrap be timed exactly at nine cycles per period with a load of 2. Short load values keep the one-shot expiry, the HOLD state and several periodic reloads within a few hundred cycles.

// File: rtl/moddown_pkg.sv
package moddown_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } md_state_e;

    // control word bit positions (software visible)
    localparam int CTL_EN    = 0;
    localparam int CTL_PER   = 1;
    localparam int CTL_RSEL  = 2;
    localparam int CTL_FORCE = 3;

    localparam logic ADDR_CTRL  = 1'b0;
    localparam logic ADDR_COUNT = 1'b1;

endpackage

// File: rtl/moddown_prescaler.sv
module moddown_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_div
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] pre_q;

            always_ff @(posedge clk) begin
                if (rst || clr || !run) begin
                    pre_q <= '0;
                end else if (pre_q == LAST) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + PW'(1);
                end
            end

            always_comb tick = run && (pre_q == LAST);

            // R9: ticks are never back to back when dividing
            p_tick_gap_r9: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end else begin : g_pass
            always_comb tick = run;
        end
    endgenerate

endmodule

// File: rtl/moddown_regs.sv
module moddown_regs
    import moddown_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic          en_q,
    output logic          per_q,
    output logic          rsel_q,
    output logic [CW-1:0] load_q,
    output logic          start,
    output logic          stop,
    output logic          force_ld,
    output logic          cnt_wr
);
    logic ctrl_wr;

    always_comb begin
        ctrl_wr  = bus_wr && (bus_addr == ADDR_CTRL);
        cnt_wr   = bus_wr && (bus_addr == ADDR_COUNT);
        start    = ctrl_wr && bus_wdata[CTL_EN] && !en_q;
        stop     = ctrl_wr && !bus_wdata[CTL_EN] && en_q;
        force_ld = ctrl_wr && bus_wdata[CTL_FORCE] && bus_wdata[CTL_EN] && en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            per_q  <= 1'b0;
            rsel_q <= 1'b0;
            load_q <= '0;
        end else begin
            if (ctrl_wr) begin
                en_q   <= bus_wdata[CTL_EN];
                per_q  <= bus_wdata[CTL_PER];
                rsel_q <= bus_wdata[CTL_RSEL];
            end
            if (cnt_wr) begin
                load_q <= bus_wdata;
            end
        end
    end

    // R12: control fields and load value only move on a write
    p_ctl_stable_r12: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> ($stable(en_q) && $stable(per_q) && $stable(rsel_q) && $stable(load_q)));

endmodule

// File: rtl/moddown_core.sv
module moddown_core
    import moddown_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_q,
    input  logic          per_q,
    input  logic          start,
    input  logic          stop,
    input  logic          force_ld,
    input  logic          cnt_wr,
    input  logic [CW-1:0] wdata,
    input  logic [CW-1:0] load_q,
    input  logic          tick,
    output logic [CW-1:0] count_q,
    output logic          zero_pulse,
    output logic          run,
    output logic          pre_clr
);
    localparam logic [CW-1:0] DIS_VAL = CW'(8'hFF);
    localparam logic [CW-1:0] ONE     = CW'(1);

    md_state_e     state_q, state_d;
    logic [CW-1:0] count_d;
    logic          zp_d;
    logic          restart;
    logic [CW-1:0] restart_val;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and datapath outputs
    always_comb begin
        state_d     = state_q;
        count_d     = count_q;
        zp_d        = 1'b0;
        restart     = force_ld || (cnt_wr && en_q);
        restart_val = force_ld ? load_q : wdata;

        if (!en_q) begin
            count_d = DIS_VAL;
            state_d = start ? ST_RUN : ST_IDLE;
        end else if (stop) begin
            count_d = DIS_VAL;
            state_d = ST_IDLE;
        end else if (restart) begin
            count_d = restart_val;
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (tick) begin
                        if (count_q == '0) begin
                            if (per_q) begin
                                count_d = load_q;
                            end else begin
                                state_d = ST_HOLD;
                            end
                        end else begin
                            count_d = count_q - ONE;
                            if (count_q == ONE) begin
                                zp_d = 1'b1;
                                if (!per_q) begin
                                    state_d = ST_HOLD;
                                end
                            end
                        end
                    end
                end
                ST_HOLD: begin
                    count_d = count_q;
                end
                ST_IDLE: begin
                    state_d = ST_RUN;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end

        run     = (state_q == ST_RUN);
        pre_clr = restart || stop || !en_q || (state_q != ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q    <= '0;
            zero_pulse <= 1'b0;
        end else begin
            count_q    <= count_d;
            zero_pulse <= zp_d;
        end
    end

    // R1: a finished one-shot sits at zero
    p_hold_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && en_q) |-> (count_q == '0));

    // R2: periodic wrap takes the load value
    p_wrap_load_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && en_q && tick && !restart && !stop && per_q && count_q == '0)
        |=> (count_q == $past(load_q)));

    // R4: force-load copies the load register
    p_force_copy_r4: assert property (@(posedge clk) disable iff (rst)
        force_ld |=> (count_q == $past(load_q)));

    // R7: a disabled counter parks at 0x00FF
    p_park_ff_r7: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> (count_q == DIS_VAL));

    // R10: the pulse marks a zero count and lasts one cycle
    p_pulse_zero_r10: assert property (@(posedge clk) disable iff (rst)
        zero_pulse |-> (count_q == '0));
    p_pulse_short_r10: assert property (@(posedge clk) disable iff (rst)
        zero_pulse |=> !zero_pulse);

endmodule

// File: rtl/moddown_timer.sv
module moddown_timer
    import moddown_pkg::*;
#(
    parameter int CW  = 16,
    parameter int DIV = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    output logic          zero_pulse
);
    logic          en_q, per_q, rsel_q;
    logic [CW-1:0] load_q, count_q;
    logic          start, stop, force_ld, cnt_wr;
    logic          tick, run, pre_clr;

    moddown_regs #(.CW(CW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .en_q     (en_q),
        .per_q    (per_q),
        .rsel_q   (rsel_q),
        .load_q   (load_q),
        .start    (start),
        .stop     (stop),
        .force_ld (force_ld),
        .cnt_wr   (cnt_wr)
    );

    moddown_prescaler #(.DIV(DIV)) u_pre (
        .clk (clk),
        .rst (rst),
        .clr (pre_clr),
        .run (run),
        .tick(tick)
    );

    moddown_core #(.CW(CW)) u_core (
        .clk       (clk),
        .rst       (rst),
        .en_q      (en_q),
        .per_q     (per_q),
        .start     (start),
        .stop      (stop),
        .force_ld  (force_ld),
        .cnt_wr    (cnt_wr),
        .wdata     (bus_wdata),
        .load_q    (load_q),
        .tick      (tick),
        .count_q   (count_q),
        .zero_pulse(zero_pulse),
        .run       (run),
        .pre_clr   (pre_clr)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL) begin
            bus_rdata[CTL_EN]   = en_q;
            bus_rdata[CTL_PER]  = per_q;
            bus_rdata[CTL_RSEL] = rsel_q;
        end else begin
            bus_rdata = rsel_q ? load_q : count_q;
        end
    end

endmodule

// File: tb/moddown_timer_tb_top.sv
module moddown_timer_tb_top;
    localparam int DIV = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b1;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        zero_pulse;

    int n_checks = 0;
    int n_fails  = 0;
    int pulses   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    moddown_timer #(.CW(16), .DIV(DIV)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .zero_pulse(zero_pulse)
    );

    // behavioural reference: 0 idle, 1 counting, 2 finished
    int          m_st = 0;
    int          m_pre = 0;
    logic [15:0] m_cnt = 0, m_load = 0;
    bit          m_en = 0, m_per = 0, m_rsel = 0, m_zp = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_pre = 0; m_cnt = 0; m_load = 0;
            m_en = 0; m_per = 0; m_rsel = 0; m_zp = 0;
        end else begin
            bit cw, lw, go, halt, frc, rs, tk;
            int nst, npre;
            logic [15:0] ncnt;
            cw   = bus_wr && !bus_addr;
            lw   = bus_wr && bus_addr;
            go   = cw && bus_wdata[0] && !m_en;
            halt = cw && !bus_wdata[0] && m_en;
            frc  = cw && bus_wdata[3] && bus_wdata[0] && m_en;
            rs   = frc || (lw && m_en);
            tk   = (m_st == 1) && (m_pre == DIV - 1);
            nst = m_st; ncnt = m_cnt; m_zp = 0;
            if (!m_en || halt) begin
                ncnt = 16'h00FF;
                nst  = go ? 1 : 0;
            end else if (rs) begin
                ncnt = frc ? m_load : bus_wdata;
                nst  = 1;
            end else if (m_st == 1 && tk) begin
                if (m_cnt == 0) begin
                    if (m_per) ncnt = m_load; else nst = 2;
                end else begin
                    ncnt = m_cnt - 1;
                    if (ncnt == 0) begin
                        m_zp = 1;
                        if (!m_per) nst = 2;
                    end
                end
            end
            if (m_st != 1 || rs || halt || !m_en) npre = 0;
            else npre = (m_pre + 1) % DIV;
            if (cw) begin m_en = bus_wdata[0]; m_per = bus_wdata[1]; m_rsel = bus_wdata[2]; end
            if (lw) m_load = bus_wdata;
            m_st = nst; m_cnt = ncnt; m_pre = npre;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [15:0] e;
            if (!bus_addr) e = {13'b0, m_rsel, m_per, m_en};
            else e = m_rsel ? m_load : m_cnt;
            chk("R3/R7/R9 model rdata", bus_rdata, e);
            chk("R10 model zero_pulse", {15'b0, zero_pulse}, {15'b0, m_zp});
            if (zero_pulse) pulses++;
        end
    end

    task automatic wr(input logic a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_addr = 1'b1; bus_wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        @(posedge clk); #1;
        bus_addr = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 count in reset", bus_rdata, 16'h0000);
        chk("R11 pulse in reset", {15'b0, zero_pulse}, 16'h0000);
        bus_addr = 1'b0;
        @(negedge clk);
        chk("R11 ctrl in reset", bus_rdata, 16'h0000);
        bus_addr = 1'b1;
        @(posedge clk); #1 rst = 1'b0;

        // R7: parked while disabled
        repeat (2) @(negedge clk);
        chk("R7 parked count", bus_rdata, 16'h00FF);

        // R8 / R3: load write while disabled, read back via select
        wr(1'b1, 16'h0005);
        @(negedge clk);
        chk("R8 count unchanged while disabled", bus_rdata, 16'h00FF);
        wr(1'b0, 16'h0004);
        @(negedge clk);
        chk("R3 select reads load", bus_rdata, 16'h0005);
        wr(1'b0, 16'h0000);

        // R5 / R6: force while disabled
        wr(1'b0, 16'h0008);
        @(negedge clk);
        chk("R5 force ignored when disabled", bus_rdata, 16'h00FF);
        rd(1'b0, v);
        chk("R6 force bit reads zero", v, 16'h0000);

        // one-shot run
        wr(1'b0, 16'h0001);
        wr(1'b1, 16'h0005);
        pulses = 0;
        @(negedge clk);
        chk("R8 restart value", bus_rdata, 16'h0005);
        repeat (2) @(negedge clk);
        chk("R9 no decrement before DIV", bus_rdata, 16'h0005);
        @(negedge clk);
        chk("R9 decrement after DIV", bus_rdata, 16'h0004);
        repeat (36) @(negedge clk);
        chk("R1 holds at zero", bus_rdata, 16'h0000);
        chk("R10 one pulse in one-shot", 16'(pulses), 16'd1);

        // R3 select while finished, then R6 write with bit 3 clear
        wr(1'b0, 16'h0005);
        @(negedge clk);
        chk("R3 select returns load", bus_rdata, 16'h0005);
        wr(1'b0, 16'h0001);
        @(negedge clk);
        chk("R6 zero force bit does nothing", bus_rdata, 16'h0000);

        // R4: force-load restarts from load and resets prescaler
        wr(1'b0, 16'h0009);
        @(negedge clk);
        chk("R4 force copies load", bus_rdata, 16'h0005);
        repeat (2) @(negedge clk);
        chk("R4 prescaler restarted", bus_rdata, 16'h0005);
        @(negedge clk);
        chk("R4 first tick after force", bus_rdata, 16'h0004);
        rd(1'b0, v);
        chk("R6 ctrl after force", v, 16'h0001);

        // periodic run
        wr(1'b0, 16'h0000);
        wr(1'b0, 16'h0003);
        wr(1'b1, 16'h0002);
        pulses = 0;
        repeat (7) @(negedge clk);
        chk("R10 periodic reaches zero", bus_rdata, 16'h0000);
        repeat (3) @(negedge clk);
        chk("R2 periodic reload", bus_rdata, 16'h0002);
        repeat (35) @(negedge clk);
        chk("R2 periodic pulse count", 16'(pulses), 16'd5);

        // R12: field positions
        wr(1'b0, 16'h0007);
        rd(1'b0, v);
        chk("R12 ctrl fields", v, 16'h0007);
        wr(1'b0, 16'h0000);
        @(negedge clk);
        chk("R7 parked after disable", bus_rdata, 16'h00FF);

        repeat (3) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule